// File: doc/BRIEF.md
# Three-Source Priority Interrupt Arbiter with Poll Mode

This block arbitrates interrupts for a small 4-bit processor core. There are three event sources. The first is an external pin, where any change of level counts as an event. The other two are underflow pulses from timer 1 and timer 2. Each source has a sticky pending flag, and every event sets that flag whatever the masking. A core-written 4-bit control register holds one mode bit per source. When a mode bit is 1, the source is allowed to interrupt the core. When it is 0, the source is meant to be polled by software with a skip test.

A global enable flag gates every interrupt. An enable strobe sets it. A disable strobe clears it, and it also clears by itself whenever the core acknowledges an interrupt, so a handler cannot be interrupted again until software re-enables. Pending sources compete under a fixed priority: the external pin first, then timer 1, then timer 2. The winner's vector is placed on the outputs: page 1, at address 0, 4 or 6.

A skip test names a source. When that source is in poll mode and its flag is set, the test reports that the next instruction is skipped, and the flag clears.

Top module: `intArbiter`

## Requirements
- R1: After reset, irqReq is 0, skipTaken is 0, ctrlRdata is 0 and the global enable flag is 0.
- R2: irqReq is 1 exactly when the global enable flag is 1 and at least one source has both its pending flag and its mode bit set to 1.
- R3: An eiStb pulse sets the global enable flag from the next cycle. A diStb pulse clears it from the next cycle. If both pulse in the same cycle, diStb wins.
- R4: irqAck while irqReq is 1 clears the global enable flag and the winning source's pending flag from the next cycle. All other pending flags are kept.
- R5: Priority is the external source, then timer 1, then timer 2. While irqReq is 1, vecPage is 1 and vecAddr is 0 for the external source, 4 for timer 1 and 6 for timer 2.
- R6: A pending flag is set by its event even while masked by the global flag or its mode bit. It stays set until it is cleared, so a masked event raises irqReq as soon as the mask is lifted.
- R7: extPin passes through a two-flop synchronizer. A rising or a falling change sampled at clock edge k sets the external pending flag, which is visible after edge k+2. A timer pulse sampled at edge k sets its flag, which is visible after edge k.
- R8: skipTaken is 1 while skipStb is 1, the source named by skipSel (0 external, 1 timer 1, 2 timer 2) has its mode bit at 0, and its flag is set. A taken skip clears that flag at the next edge. With the mode bit at 1, or with skipSel equal to 3, the skip test never skips and no flag is changed.
- R9: The control register is written with ctrlWe. Bit 0 is the external mode bit, bit 2 is timer 1 and bit 3 is timer 2. Bit 1 always reads 0.
- R10: An event arriving in the same cycle as the clear of its flag, whether by acknowledge or by a taken skip, leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | Asynchronous external interrupt pin |
| tmr1Uflow | input | 1 | Timer 1 underflow pulse |
| tmr2Uflow | input | 1 | Timer 2 underflow pulse |
| eiStb | input | 1 | Set the global enable flag |
| diStb | input | 1 | Clear the global enable flag |
| ctrlWe | input | 1 | Write strobe for the control register |
| ctrlWdata | input | 4 | Control register write data |
| ctrlRdata | output | 4 | Control register read data |
| skipStb | input | 1 | Skip test strobe |
| skipSel | input | 2 | Source named by the skip test |
| skipTaken | output | 1 | The skip test skips |
| irqAck | input | 1 | Core accepts the current interrupt |
| irqReq | output | 1 | Interrupt request to the core |
| vecPage | output | 2 | Vector page |
| vecAddr | output | 7 | Vector address within the page |

## Verification
Arbitration is exercised with several patterns. In the first, two timer events arrive while everything is masked. Releasing the masks then shows that flags latch and that timer 1 is served before timer 2. Next, external pin changes arrive alone and together with a timer event, which pins the synchronizer latency, confirms that both edge polarities count, and shows the top priority of the pin. Skip tests are applied in both modes and to the unused select to tell poll mode apart from interrupt mode. Events placed in the very cycle of an acknowledge or a taken skip show whether set wins over clear.

// File: rtl/intArbPkg.sv
package intArbPkg;
  localparam int SRC_COUNT = 3;
  localparam int CTRL_W    = 4;
  localparam int PAGE_W    = 2;
  localparam int ADDR_W    = 7;
  localparam int SEL_W     = 2;

  typedef struct packed {
    logic [SRC_COUNT-1:0] clrFlag;
    logic                 clrGie;
  } ctlStb_t;

  // control register bit that holds the mode bit of source i
  function automatic int modeBitOf(int i);
    return (i == 0) ? 0 : i + 1;
  endfunction

  // vector address inside page 1 for source i
  function automatic int vecOf(int i);
    return (i == 0) ? 0 : 2 + 2 * i;
  endfunction
endpackage

// File: rtl/intArbData.sv
module intArbData
  import intArbPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extPin,
  input  logic                 tmr1Uflow,
  input  logic                 tmr2Uflow,
  input  logic                 eiStb,
  input  logic                 diStb,
  input  logic                 ctrlWe,
  input  logic [CTRL_W-1:0]    ctrlWdata,
  input  ctlStb_t              stb,
  output logic [CTRL_W-1:0]    ctrlRdata,
  output logic [SRC_COUNT-1:0] pendQ,
  output logic [SRC_COUNT-1:0] modeQ,
  output logic                 gieQ
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastQ;
  logic                   extEdge;
  logic [SRC_COUNT-1:0]   trig;

  // synchronizer chain plus one history flop for change detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      lastQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign extEdge = syncQ[SYNC_STAGES-1] ^ lastQ;
  assign trig    = {tmr2Uflow, tmr1Uflow, extEdge};

  // sticky pending flags, set beats clear
  for (genvar i = 0; i < SRC_COUNT; i++) begin : gPend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              pendQ[i] <= 1'b0;
      else if (trig[i])       pendQ[i] <= 1'b1;
      else if (stb.clrFlag[i]) pendQ[i] <= 1'b0;
    end
  end

  // mode bits and read-back mapping
  for (genvar i = 0; i < SRC_COUNT; i++) begin : gMode
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       modeQ[i] <= 1'b0;
      else if (ctrlWe) modeQ[i] <= ctrlWdata[modeBitOf(i)];
    end
  end

  always_comb begin
    ctrlRdata = '0;
    for (int i = 0; i < SRC_COUNT; i++) ctrlRdata[modeBitOf(i)] = modeQ[i];
  end

  logic unusedWbit;
  assign unusedWbit = ctrlWdata[1];

  // global enable: disable and acknowledge win over enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    gieQ <= 1'b0;
    else if (diStb || stb.clrGie) gieQ <= 1'b0;
    else if (eiStb)               gieQ <= 1'b1;
  end
endmodule

// File: rtl/intArbCtrl.sv
module intArbCtrl
  import intArbPkg::*;
(
  input  logic [SRC_COUNT-1:0] pendQ,
  input  logic [SRC_COUNT-1:0] modeQ,
  input  logic                 gieQ,
  input  logic                 irqAck,
  input  logic                 skipStb,
  input  logic [SEL_W-1:0]     skipSel,
  output ctlStb_t              stb,
  output logic                 irqReq,
  output logic [PAGE_W-1:0]    vecPage,
  output logic [ADDR_W-1:0]    vecAddr,
  output logic                 skipTaken
);
  logic [SRC_COUNT-1:0] live;
  logic [SRC_COUNT-1:0] winner;
  logic [SRC_COUNT-1:0] skipHit;

  assign live   = pendQ & modeQ;
  assign irqReq = gieQ && (|live);

  // fixed priority: lowest index wins
  always_comb begin
    winner  = '0;
    vecAddr = '0;
    for (int i = SRC_COUNT - 1; i >= 0; i--) begin
      if (live[i]) begin
        winner  = '0;
        winner[i] = 1'b1;
        vecAddr = ADDR_W'(vecOf(i));
      end
    end
  end

  assign vecPage = PAGE_W'(1);

  // poll mode skip decision
  always_comb begin
    skipHit = '0;
    for (int i = 0; i < SRC_COUNT; i++)
      if (skipStb && skipSel == SEL_W'(i) && !modeQ[i] && pendQ[i])
        skipHit[i] = 1'b1;
  end

  assign skipTaken = |skipHit;

  always_comb begin
    stb.clrGie  = irqAck && irqReq;
    stb.clrFlag = skipHit | ((irqAck && irqReq) ? winner : '0);
  end
endmodule

// File: rtl/intArbiter.sv
module intArbiter
  import intArbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              tmr1Uflow,
  input  logic              tmr2Uflow,
  input  logic              eiStb,
  input  logic              diStb,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic [CTRL_W-1:0] ctrlRdata,
  input  logic              skipStb,
  input  logic [SEL_W-1:0]  skipSel,
  output logic              skipTaken,
  input  logic              irqAck,
  output logic              irqReq,
  output logic [PAGE_W-1:0] vecPage,
  output logic [ADDR_W-1:0] vecAddr
);
  ctlStb_t              stb;
  logic [SRC_COUNT-1:0] pendQ;
  logic [SRC_COUNT-1:0] modeQ;
  logic                 gieQ;

  intArbData #(.SYNC_STAGES(2)) uData (
    .clk(clk), .rstN(rstN), .extPin(extPin),
    .tmr1Uflow(tmr1Uflow), .tmr2Uflow(tmr2Uflow),
    .eiStb(eiStb), .diStb(diStb),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .stb(stb),
    .ctrlRdata(ctrlRdata), .pendQ(pendQ), .modeQ(modeQ), .gieQ(gieQ)
  );

  intArbCtrl uCtrl (
    .pendQ(pendQ), .modeQ(modeQ), .gieQ(gieQ), .irqAck(irqAck),
    .skipStb(skipStb), .skipSel(skipSel), .stb(stb),
    .irqReq(irqReq), .vecPage(vecPage), .vecAddr(vecAddr),
    .skipTaken(skipTaken)
  );
endmodule

// File: rtl/intArbChecker.sv
module intArbChecker
  import intArbPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 eiStb,
  input logic                 diStb,
  input logic                 irqAck,
  input logic                 irqReq,
  input logic                 skipStb,
  input logic                 skipTaken,
  input logic [CTRL_W-1:0]    ctrlRdata,
  input logic [PAGE_W-1:0]    vecPage,
  input logic [ADDR_W-1:0]    vecAddr,
  input logic [SRC_COUNT-1:0] pendQ,
  input logic [SRC_COUNT-1:0] modeQ,
  input logic                 gieQ
);
  a_r2_req_needs_all: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (gieQ && (|(pendQ & modeQ))));

  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rstN)
    diStb |=> !gieQ);

  a_r3_ei_sets: assert property (@(posedge clk) disable iff (!rstN)
    (eiStb && !diStb && !irqAck) |=> gieQ);

  a_r4_ack_clears_gie: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> !gieQ);

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecPage == PAGE_W'(1) &&
                (vecAddr == 0 || vecAddr == 4 || vecAddr == 6)));

  a_r8_skip_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    skipTaken |-> skipStb);

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[1] == 1'b0);
endmodule

bind intArbiter intArbChecker uChk (
  .clk(clk), .rstN(rstN), .eiStb(eiStb), .diStb(diStb), .irqAck(irqAck),
  .irqReq(irqReq), .skipStb(skipStb), .skipTaken(skipTaken),
  .ctrlRdata(ctrlRdata), .vecPage(vecPage), .vecAddr(vecAddr),
  .pendQ(pendQ), .modeQ(modeQ), .gieQ(gieQ)
);

// File: tb/tb_intArbiter.sv
module tb_intArbiter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extPin = 1'b0, tmr1Uflow = 1'b0, tmr2Uflow = 1'b0;
  logic       eiStb = 1'b0, diStb = 1'b0, ctrlWe = 1'b0;
  logic [3:0] ctrlWdata = '0;
  logic [3:0] ctrlRdata;
  logic       skipStb = 1'b0;
  logic [1:0] skipSel = '0;
  logic       skipTaken, irqAck = 1'b0, irqReq;
  logic [1:0] vecPage;
  logic [6:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intArbiter dut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .tmr1Uflow(tmr1Uflow),
    .tmr2Uflow(tmr2Uflow), .eiStb(eiStb), .diStb(diStb), .ctrlWe(ctrlWe),
    .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata), .skipStb(skipStb),
    .skipSel(skipSel), .skipTaken(skipTaken), .irqAck(irqAck),
    .irqReq(irqReq), .vecPage(vecPage), .vecAddr(vecAddr)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCtrl(logic [3:0] v);
    ctrlWdata = v; ctrlWe = 1'b1; tick(); ctrlWe = 1'b0;
  endtask

  task automatic pulseEi();
    eiStb = 1'b1; tick(); eiStb = 1'b0;
  endtask

  task automatic pulseAck();
    irqAck = 1'b1; tick(); irqAck = 1'b0;
  endtask

  task automatic pulseT1();
    tmr1Uflow = 1'b1; tick(); tmr1Uflow = 1'b0;
  endtask

  task automatic pulseT2();
    tmr2Uflow = 1'b1; tick(); tmr2Uflow = 1'b0;
  endtask

  task automatic testReset();
    check("R1 irqReq", irqReq, 0);
    check("R1 skipTaken", skipTaken, 0);
    check("R1 ctrlRdata", ctrlRdata, 0);
    writeCtrl(4'hD);
    check("R1 gie off", irqReq, 0);
    writeCtrl(4'h0);
  endtask

  task automatic testCtrlReg();
    writeCtrl(4'hF);
    check("R9 bit1 reads 0", ctrlRdata, 4'hD);
    writeCtrl(4'h4);
    check("R9 timer1 at bit2", ctrlRdata, 4'h4);
    writeCtrl(4'h0);
  endtask

  task automatic testMaskedLatch();
    pulseT2(); pulseT1();
    check("R6 masked no req", irqReq, 0);
    writeCtrl(4'hD);
    check("R6 gie still off", irqReq, 0);
    pulseEi();
    check("R6 released req", irqReq, 1);
    check("R5 timer1 over timer2", vecAddr, 4);
    check("R5 page", vecPage, 1);
    pulseAck();
    check("R4 gie cleared", irqReq, 0);
    pulseEi();
    check("R4 timer2 kept", vecAddr, 6);
    check("R2 req", irqReq, 1);
    pulseAck();
    pulseEi();
    check("R4 all served", irqReq, 0);
  endtask

  task automatic testExtEdge();
    extPin = 1'b1;
    tick(); tick();
    check("R7 not yet after 2 edges", irqReq, 0);
    tick();
    check("R7 rising sets after 3 edges", irqReq, 1);
    check("R5 ext vector", vecAddr, 0);
    pulseAck();
    pulseEi();
    extPin = 1'b0;
    tmr1Uflow = 1'b1; tick(); tmr1Uflow = 1'b0;
    tick(); tick();
    check("R5 ext over timer1", vecAddr, 0);
    check("R7 falling sets", irqReq, 1);
    pulseAck(); pulseEi();
    check("R5 timer1 next", vecAddr, 4);
    pulseAck(); pulseEi();
    check("R7 no spurious edge", irqReq, 0);
  endtask

  task automatic testSkip();
    writeCtrl(4'h0);
    pulseT1();
    skipSel = 2'd1; skipStb = 1'b1; #1;
    check("R8 poll skip", skipTaken, 1);
    tick();
    check("R8 flag cleared", skipTaken, 0);
    skipStb = 1'b0;
    skipSel = 2'd3; skipStb = 1'b1; #1;
    check("R8 sel3 never", skipTaken, 0);
    skipStb = 1'b0;
    writeCtrl(4'h4);
    pulseT1();
    skipSel = 2'd1; skipStb = 1'b1; #1;
    check("R8 intr mode no skip", skipTaken, 0);
    tick(); skipStb = 1'b0;
    check("R8 flag kept", irqReq, 1);
    check("R8 flag kept vec", vecAddr, 4);
    pulseAck(); pulseEi();
  endtask

  task automatic testEnableDisable();
    writeCtrl(4'h0);
    pulseT2();
    writeCtrl(4'h8);
    check("R3 gie set", irqReq, 1);
    diStb = 1'b1; tick(); diStb = 1'b0;
    check("R3 di clears", irqReq, 0);
    eiStb = 1'b1; diStb = 1'b1; tick(); eiStb = 1'b0; diStb = 1'b0;
    check("R3 di wins", irqReq, 0);
    pulseEi();
    check("R3 ei sets", irqReq, 1);
  endtask

  task automatic testCollision();
    // timer2 pending, gie on
    irqAck = 1'b1; tmr2Uflow = 1'b1; tick(); irqAck = 1'b0; tmr2Uflow = 1'b0;
    check("R10 ack cleared gie", irqReq, 0);
    pulseEi();
    check("R10 ack collision keeps flag", irqReq, 1);
    pulseAck();
    writeCtrl(4'h0);
    pulseT2();
    skipSel = 2'd2; skipStb = 1'b1; tmr2Uflow = 1'b1; tick();
    skipStb = 1'b0; tmr2Uflow = 1'b0;
    skipStb = 1'b1; #1;
    check("R10 skip collision keeps flag", skipTaken, 1);
    tick(); skipStb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testCtrlReg();
    testMaskedLatch();
    writeCtrl(4'hD); pulseEi();
    testExtEdge();
    testSkip();
    testEnableDisable();
    testCollision();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule